// File: doc/BRIEF.md
# Pixel Bit-Depth Reducer with Dithering

This block sits at the end of a display pixel pipeline. It takes one pixel per clock with three 12-bit colour components and cuts each component to 6 or 8 significant bits. Depending on the active configuration, a component passes through untouched, loses its low bits by plain truncation, is rounded half-up, or is spatially dithered. Dithering adds pseudo-random noise from a 28-bit linear feedback shift register per channel before the low bits are dropped. Results keep their 12-bit width and are left-aligned, with the dropped bits forced to zero. Every result is registered, so it appears one cycle after its input.

The configuration comes in as a set of static-looking inputs. The block samples it only on a start-of-frame pulse, so upstream logic can change settings at any time without tearing a frame. The noise generators can share one feedback polynomial or use a different one per channel. They can reload their seeds at every frame or only at the first frame after reset. Their output can pass through a first-difference high-pass filter.

Top module: `pxr_depth_reducer`

## Requirements
- R1: While and after reset, before any valid pixel, `out_valid` is 0 and all three output components are 0; the active configuration resets to all-zero, which means pass-through.
- R2: `out_valid` equals `pix_valid` delayed by one clock. Output components change only in the cycle after a valid pixel and hold their value otherwise.
- R3: With dithering inactive and truncation disabled, or with truncation depth code 2 or 3, each output component equals its input component.
- R4: Truncation with rounding flag 0 clears the low 6 bits (depth code 0, 6 kept bits) or the low 4 bits (depth code 1, 8 kept bits) of each component.
- R5: Truncation with rounding flag 1 adds half of the dropped range (32 for depth 0, 8 for depth 1), saturates the sum at 4095 and then clears the dropped bits, so 4095 at depth 0 gives 4032.
- R6: The configuration inputs are captured only in a cycle with `sof` high, and the pixel presented in that same cycle already uses them. Changes while `sof` is low have no effect on the outputs.
- R7: With dithering active, each component becomes min(in + n, 4095) with the dropped bits cleared. The noise n is the low 6 bits of the channel's generator state, masked to the dropped bit count (6 for dither depth code 0, 4 for code 1).
- R8: Each generator steps as s_next = {s[26:0], s[27] ^ s[k-1]}, i.e. polynomial x^28 + x^k + 1. k is 3 for all channels when the per-channel flag is 0. When it is 1, k is 3 for R, 9 for G and 13 for B.
- R9: A generator advances exactly once per cycle with `pix_valid` high and keeps its state while `pix_valid` is low.
- R10: At a `sof` cycle, the generators load their seeds if the frame-reseed flag is 1, or if no `sof` has occurred since reset. Otherwise they continue from their current state. The pixel in the loading cycle uses the seed as its state.
- R11: With the high-pass flag set, n is (raw - prev) modulo 2^dropped, where raw is the current 6-bit sample. prev is the raw sample of the last valid pixel, or 0 if there has been none since reset.
- R12: A dither depth code of 2 or 3 leaves dithering inactive, and the truncation settings then decide the result; an active dither overrides truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse; captures configuration, may reload seeds |
| pix_valid | input | 1 | Pixel strobe |
| r_in | input | 12 | Red / Cr component |
| g_in | input | 12 | Green / Y component |
| b_in | input | 12 | Blue / Cb component |
| cfg_trunc_en | input | 1 | Truncation enable |
| cfg_trunc_depth | input | 2 | Truncation depth code: 0 = 6 bits, 1 = 8 bits, 2/3 = none |
| cfg_trunc_round | input | 1 | 0 = drop bits, 1 = round half-up with saturation |
| cfg_dith_en | input | 1 | Spatial dither enable |
| cfg_dith_depth | input | 2 | Dither depth code: 0 = 6 bits, 1 = 8 bits, 2/3 = dither off |
| cfg_per_chan | input | 1 | 1 = per-channel feedback taps, 0 = shared tap |
| cfg_frame_reseed | input | 1 | 1 = reload seeds at every frame start |
| cfg_highpass | input | 1 | 1 = first-difference filter on noise |
| seed_r | input | 28 | Red generator seed |
| seed_g | input | 28 | Green generator seed |
| seed_b | input | 28 | Blue generator seed |
| out_valid | output | 1 | Output strobe, one cycle after `pix_valid` |
| r_out | output | 12 | Reduced red, left-aligned |
| g_out | output | 12 | Reduced green, left-aligned |
| b_out | output | 12 | Reduced blue, left-aligned |

## Verification
The assertions assume that every input carries a known value from the first clock after reset onward. They also assume that `sof` and `pix_valid` are driven as single-cycle qualifiers, not glitching within a cycle. The bench respects this: it holds every input at a defined value during reset and changes inputs only on the falling clock edge. Seeds are kept non-zero, so the generators never lock up in the all-zero state and the noise paths are actually exercised.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

    localparam int PIX_W_DEF   = 12;
    localparam int LFSR_W_DEF  = 28;
    localparam int KEEP_NARROW = 6;
    localparam int KEEP_WIDE   = 8;
    localparam int SHARED_TAP  = 3;
    localparam int NCH         = 3;

    // Captured frame configuration
    typedef struct packed {
        logic       trunc_en;
        logic [1:0] trunc_depth;
        logic       trunc_round;
        logic       dith_en;
        logic [1:0] dith_depth;
        logic       per_chan;
        logic       frame_reseed;
        logic       highpass;
    } pxr_cfg_t;

    typedef enum logic [1:0] {
        RED_PASS   = 2'd0,
        RED_CUT    = 2'd1,
        RED_ROUND  = 2'd2,
        RED_DITHER = 2'd3
    } pxr_mode_e;

    // Feedback tap used by a channel when per-channel polynomials are chosen
    function automatic int chan_tap(input int ch);
        case (ch)
            0:       return 3;
            1:       return 9;
            default: return 13;
        endcase
    endfunction

    // One step of a Fibonacci shift register, polynomial x^W + x^tap + 1
    function automatic logic [LFSR_W_DEF-1:0] lfsr_next(
        input logic [LFSR_W_DEF-1:0] s,
        input int                    tap
    );
        return {s[LFSR_W_DEF-2:0], s[LFSR_W_DEF-1] ^ s[tap-1]};
    endfunction

endpackage

// File: rtl/pxr_noise_gen.sv
module pxr_noise_gen
    import pxr_pkg::*;
#(
    parameter int LFSR_W  = LFSR_W_DEF,
    parameter int NOISE_W = 6,
    parameter int DROP_W  = 4,
    parameter int OWN_TAP = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic               reload,
    input  logic [LFSR_W-1:0]  seed,
    input  logic               per_chan,
    input  logic               highpass,
    input  logic [DROP_W-1:0]  drop,
    output logic [NOISE_W-1:0] noise
);

    logic [LFSR_W-1:0]  state_q;
    logic [LFSR_W-1:0]  eff;
    logic [NOISE_W-1:0] prev_q;
    logic [NOISE_W-1:0] raw;
    logic [NOISE_W-1:0] diff;
    logic [NOISE_W-1:0] nmask;
    int                 tap;

    always_comb begin
        eff   = reload ? seed : state_q;
        raw   = eff[NOISE_W-1:0];
        diff  = raw - prev_q;
        nmask = NOISE_W'((32'd1 << drop) - 32'd1);
        noise = (highpass ? diff : raw) & nmask;
        tap   = per_chan ? OWN_TAP : SHARED_TAP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            prev_q  <= '0;
        end else if (valid) begin
            state_q <= lfsr_next(eff, tap);
            prev_q  <= raw;
        end else begin
            state_q <= eff;
        end
    end

    // R9: no pixel and no reload -> generator frozen
    a_r9_lfsr_hold: assert property (@(posedge clk) disable iff (rst)
        (!valid && !reload) |=> $stable(state_q));

    // R10: a reload in an idle cycle leaves the seed in the register
    a_r10_seed_load: assert property (@(posedge clk) disable iff (rst)
        (reload && !valid) |=> (state_q == $past(seed)));

endmodule

// File: rtl/pxr_chan_reduce.sv
module pxr_chan_reduce
    import pxr_pkg::*;
#(
    parameter int PIX_W   = PIX_W_DEF,
    parameter int NOISE_W = 6,
    parameter int DROP_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  pxr_mode_e          mode,
    input  logic [DROP_W-1:0]  drop,
    input  logic [PIX_W-1:0]   pix_in,
    input  logic [NOISE_W-1:0] noise,
    output logic [PIX_W-1:0]   pix_out
);

    logic [PIX_W-1:0] mask;
    logic [PIX_W-1:0] addend;
    logic [PIX_W:0]   sum;
    logic [PIX_W-1:0] sat;
    logic [PIX_W-1:0] result;
    logic [PIX_W-1:0] pix_q;

    always_comb begin
        mask = PIX_W'((32'd1 << drop) - 32'd1);
        case (mode)
            RED_DITHER: addend = {{(PIX_W-NOISE_W){1'b0}}, noise};
            RED_ROUND:  addend = PIX_W'(32'd1 << (32'(drop) - 32'd1));
            default:    addend = '0;
        endcase
        sum    = {1'b0, pix_in} + {1'b0, addend};
        sat    = sum[PIX_W] ? {PIX_W{1'b1}} : sum[PIX_W-1:0];
        result = (mode == RED_PASS) ? pix_in : (sat & ~mask);
    end

    always_ff @(posedge clk) begin
        if (rst)        pix_q <= '0;
        else if (valid) pix_q <= result;
    end

    assign pix_out = pix_q;

    // R4: every reducing mode leaves the dropped bits at zero
    a_r4_low_clear: assert property (@(posedge clk) disable iff (rst)
        (valid && mode != RED_PASS) |=> ((pix_q & $past(mask)) == '0));

    // R7: dithering never wraps below the truncated input
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (valid && mode == RED_DITHER) |=> (pix_q >= ($past(pix_in) & ~$past(mask))));

endmodule

// File: rtl/pxr_depth_reducer.sv
module pxr_depth_reducer
    import pxr_pkg::*;
#(
    parameter int PIX_W  = PIX_W_DEF,
    parameter int LFSR_W = LFSR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sof,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  r_in,
    input  logic [PIX_W-1:0]  g_in,
    input  logic [PIX_W-1:0]  b_in,
    input  logic              cfg_trunc_en,
    input  logic [1:0]        cfg_trunc_depth,
    input  logic              cfg_trunc_round,
    input  logic              cfg_dith_en,
    input  logic [1:0]        cfg_dith_depth,
    input  logic              cfg_per_chan,
    input  logic              cfg_frame_reseed,
    input  logic              cfg_highpass,
    input  logic [LFSR_W-1:0] seed_r,
    input  logic [LFSR_W-1:0] seed_g,
    input  logic [LFSR_W-1:0] seed_b,
    output logic              out_valid,
    output logic [PIX_W-1:0]  r_out,
    output logic [PIX_W-1:0]  g_out,
    output logic [PIX_W-1:0]  b_out
);

    localparam int DROP_NARROW = PIX_W - KEEP_NARROW;
    localparam int DROP_WIDE   = PIX_W - KEEP_WIDE;
    localparam int NOISE_W     = DROP_NARROW;
    localparam int DROP_W      = $clog2(PIX_W + 1);

    pxr_cfg_t          cfg_in, cfg_q, act;
    logic              seeded_q;
    logic              reload;
    logic              out_valid_q;
    pxr_mode_e         mode;
    logic [DROP_W-1:0] drop;

    logic [PIX_W-1:0]  pix_in_a  [NCH];
    logic [PIX_W-1:0]  pix_out_a [NCH];
    logic [LFSR_W-1:0] seed_a    [NCH];

    assign cfg_in = '{trunc_en:     cfg_trunc_en,
                      trunc_depth:  cfg_trunc_depth,
                      trunc_round:  cfg_trunc_round,
                      dith_en:      cfg_dith_en,
                      dith_depth:   cfg_dith_depth,
                      per_chan:     cfg_per_chan,
                      frame_reseed: cfg_frame_reseed,
                      highpass:     cfg_highpass};

    // The pixel in the frame-start cycle already sees the new settings
    assign act    = sof ? cfg_in : cfg_q;
    assign reload = sof && (cfg_in.frame_reseed || !seeded_q);

    always_comb begin
        if (act.dith_en && act.dith_depth < 2'd2) begin
            mode = RED_DITHER;
            drop = (act.dith_depth == 2'd0) ? DROP_W'(DROP_NARROW) : DROP_W'(DROP_WIDE);
        end else if (act.trunc_en && act.trunc_depth < 2'd2) begin
            mode = act.trunc_round ? RED_ROUND : RED_CUT;
            drop = (act.trunc_depth == 2'd0) ? DROP_W'(DROP_NARROW) : DROP_W'(DROP_WIDE);
        end else begin
            mode = RED_PASS;
            drop = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= '0;
            seeded_q    <= 1'b0;
            out_valid_q <= 1'b0;
        end else begin
            if (sof) begin
                cfg_q    <= cfg_in;
                seeded_q <= 1'b1;
            end
            out_valid_q <= pix_valid;
        end
    end

    assign pix_in_a[0] = r_in;
    assign pix_in_a[1] = g_in;
    assign pix_in_a[2] = b_in;
    assign seed_a[0]   = seed_r;
    assign seed_a[1]   = seed_g;
    assign seed_a[2]   = seed_b;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [NOISE_W-1:0] noise;

        pxr_noise_gen #(
            .LFSR_W (LFSR_W),
            .NOISE_W(NOISE_W),
            .DROP_W (DROP_W),
            .OWN_TAP(chan_tap(ch))
        ) u_noise (
            .clk     (clk),
            .rst     (rst),
            .valid   (pix_valid),
            .reload  (reload),
            .seed    (seed_a[ch]),
            .per_chan(act.per_chan),
            .highpass(act.highpass),
            .drop    (drop),
            .noise   (noise)
        );

        pxr_chan_reduce #(
            .PIX_W  (PIX_W),
            .NOISE_W(NOISE_W),
            .DROP_W (DROP_W)
        ) u_reduce (
            .clk    (clk),
            .rst    (rst),
            .valid  (pix_valid),
            .mode   (mode),
            .drop   (drop),
            .pix_in (pix_in_a[ch]),
            .noise  (noise),
            .pix_out(pix_out_a[ch])
        );
    end

    assign out_valid = out_valid_q;
    assign r_out     = pix_out_a[0];
    assign g_out     = pix_out_a[1];
    assign b_out     = pix_out_a[2];

    // R2: strobe latency of exactly one cycle
    a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);
    a_r2_idle_follow: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid);

    // R2: outputs frozen after an idle cycle
    a_r2_hold_data: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> $stable({r_out, g_out, b_out}));

    // R6: captured configuration only moves on a frame start
    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !sof |=> $stable(cfg_q));

endmodule

// File: tb/pxr_depth_reducer_tb.sv
`timescale 1ns/1ps
module pxr_depth_reducer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof = 1'b0;
    logic        pix_valid = 1'b0;
    logic [11:0] r_in = '0, g_in = '0, b_in = '0;
    logic        c_ten = 0, c_rnd = 0, c_den = 0, c_pch = 0, c_rs = 0, c_hp = 0;
    logic [1:0]  c_tdep = 0, c_ddep = 0;
    logic [27:0] seed_r = 28'h5A3C9E7, seed_g = 28'hB1D2E3F, seed_b = 28'h0F1E2D9;
    logic        out_valid;
    logic [11:0] r_out, g_out, b_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pxr_depth_reducer u_dut (
        .clk(clk), .rst(rst), .sof(sof), .pix_valid(pix_valid),
        .r_in(r_in), .g_in(g_in), .b_in(b_in),
        .cfg_trunc_en(c_ten), .cfg_trunc_depth(c_tdep), .cfg_trunc_round(c_rnd),
        .cfg_dith_en(c_den), .cfg_dith_depth(c_ddep), .cfg_per_chan(c_pch),
        .cfg_frame_reseed(c_rs), .cfg_highpass(c_hp),
        .seed_r(seed_r), .seed_g(seed_g), .seed_b(seed_b),
        .out_valid(out_valid), .r_out(r_out), .g_out(g_out), .b_out(b_out)
    );

    // Reference model state, built from the requirements
    logic [27:0] m_st   [3];
    logic [5:0]  m_prev [3];
    bit          m_seeded;
    logic [9:0]  m_cfg;   // {ten, tdep[1:0], rnd, den, ddep[1:0], pch, rs, hp}
    logic [11:0] e_out  [3];
    bit          e_vld;

    // Vector: {ten, tdep[1:0], rnd, in[11:0], exp[11:0]}
    localparam logic [27:0] VEC [10] = '{
        {1'b0, 2'd0, 1'b0, 12'hABC, 12'hABC},   // R3 both off
        {1'b1, 2'd0, 1'b0, 12'hABC, 12'hA80},   // R4 6-bit cut
        {1'b1, 2'd1, 1'b0, 12'hABC, 12'hAB0},   // R4 8-bit cut
        {1'b1, 2'd0, 1'b1, 12'hABC, 12'hAC0},   // R5 round up
        {1'b1, 2'd0, 1'b1, 12'h01F, 12'h000},   // R5 just below half
        {1'b1, 2'd0, 1'b1, 12'h020, 12'h040},   // R5 exactly half
        {1'b1, 2'd1, 1'b1, 12'hFFF, 12'hFF0},   // R5 saturate 8-bit
        {1'b1, 2'd0, 1'b1, 12'hFFF, 12'hFC0},   // R5 saturate 6-bit
        {1'b1, 2'd2, 1'b0, 12'hABC, 12'hABC},   // R3 depth code 2
        {1'b1, 2'd1, 1'b1, 12'h7F8, 12'h800}    // R5 carry into upper bits
    };

    function automatic logic [27:0] m_step(input logic [27:0] s, input int k);
        return {s[26:0], s[27] ^ s[k-1]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drives one cycle (called at a falling edge), models it, checks at the next falling edge
    task automatic cyc(input bit s, input bit v, input logic [11:0] r, input logic [11:0] g,
                       input logic [11:0] b, input string tag);
        logic [9:0]  a;
        bit          reload, dith;
        logic [27:0] eff, sd;
        logic [5:0]  raw, n;
        logic [11:0] mask, px, o;
        logic [12:0] sum;
        int          d, k;
        sof = s; pix_valid = v; r_in = r; g_in = g; b_in = b;
        if (s) m_cfg = {c_ten, c_tdep, c_rnd, c_den, c_ddep, c_pch, c_rs, c_hp};
        a = m_cfg;
        reload = s && (a[1] || !m_seeded);
        if (s) m_seeded = 1;
        for (int ch = 0; ch < 3; ch++) begin
            px  = (ch == 0) ? r : (ch == 1) ? g : b;
            sd  = (ch == 0) ? seed_r : (ch == 1) ? seed_g : seed_b;
            eff = reload ? sd : m_st[ch];
            raw = eff[5:0];
            dith = a[5] && (a[4:3] < 2);
            if (dith)                      d = (a[4:3] == 0) ? 6 : 4;
            else if (a[9] && a[8:7] < 2)   d = (a[8:7] == 0) ? 6 : 4;
            else                           d = 0;
            mask = 12'((32'd1 << d) - 1);
            if (dith) begin
                n   = a[0] ? 6'(raw - m_prev[ch]) : raw;
                n   = n & mask[5:0];
                sum = {1'b0, px} + {7'd0, n};
            end else if (d > 0 && a[6]) begin
                sum = {1'b0, px} + 13'(32'd1 << (d - 1));
            end else begin
                sum = {1'b0, px};
            end
            if (sum > 13'd4095) sum = 13'd4095;
            o = (d == 0) ? px : (sum[11:0] & ~mask);
            k = a[2] ? ((ch == 0) ? 3 : (ch == 1) ? 9 : 13) : 3;
            if (v) begin
                e_out[ch]  = o;
                m_prev[ch] = raw;
                m_st[ch]   = m_step(eff, k);
            end else begin
                m_st[ch] = eff;
            end
        end
        e_vld = v;
        @(negedge clk);
        chk(out_valid == e_vld, {tag, " valid"}, {11'd0, out_valid}, {11'd0, e_vld});
        chk(r_out == e_out[0], {tag, " red"},   r_out, e_out[0]);
        chk(g_out == e_out[1], {tag, " green"}, g_out, e_out[1]);
        chk(b_out == e_out[2], {tag, " blue"},  b_out, e_out[2]);
    endtask

    task automatic set_cfg(input bit ten, input logic [1:0] tdep, input bit rnd, input bit den,
                           input logic [1:0] ddep, input bit pch, input bit rs, input bit hp);
        c_ten = ten; c_tdep = tdep; c_rnd = rnd; c_den = den;
        c_ddep = ddep; c_pch = pch; c_rs = rs; c_hp = hp;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < 3; ch++) begin
            m_st[ch] = '0; m_prev[ch] = '0; e_out[ch] = '0;
        end
        m_seeded = 0; m_cfg = '0; e_vld = 0;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 valid in reset", {11'd0, out_valid}, 12'd0);
        chk({r_out, g_out, b_out} == '0, "R1 data in reset", r_out, 12'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && r_out == 0 && g_out == 0 && b_out == 0,
            "R1 after reset", r_out, 12'd0);
        // R1: zero configuration means pass-through
        cyc(0, 1, 12'h123, 12'h456, 12'h789, "R1 default pass");
        chk(g_out == 12'h456, "R1 pass value", g_out, 12'h456);

        // Table walk: R3, R4, R5
        foreach (VEC[i]) begin
            set_cfg(VEC[i][27], VEC[i][26:25], VEC[i][24], 0, 0, 0, 0, 0);
            cyc(1, 1, VEC[i][23:12], VEC[i][23:12], VEC[i][23:12], "R3/R4/R5 vector");
            chk(r_out == VEC[i][11:0], "R3/R4/R5 table", r_out, VEC[i][11:0]);
        end

        // R2: idle cycle holds outputs
        cyc(0, 0, 12'h111, 12'h222, 12'h333, "R2 idle");
        chk(r_out == 12'h800, "R2 hold", r_out, 12'h800);

        // R6: change without sof has no effect
        set_cfg(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 1, 12'hABC, 12'hABC, 12'hABC, "R6 capture");
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 12'hABC, 12'hABC, 12'hABC, "R6 no sof");
        chk(r_out == 12'hA80, "R6 old settings kept", r_out, 12'hA80);

        // R7 / R8 / R10: shared polynomial, 6 kept bits, reseed each frame
        set_cfg(0, 0, 0, 1, 0, 0, 1, 0);
        cyc(1, 1, 12'h400, 12'h800, 12'hC00, "R10 reseed frame start");
        for (int i = 0; i < 20; i++)
            cyc(0, (i % 5) != 3, 12'(i * 97), 12'(4000 - i * 61), 12'(i * 211), "R7/R8/R9 shared");
        // R7: saturation under dither
        cyc(0, 1, 12'hFFF, 12'hFFF, 12'hFFF, "R7 dither saturate");
        chk(r_out == 12'hFC0, "R7 saturated value", r_out, 12'hFC0);

        // R8 / R11: per-channel taps, 8 kept bits, high-pass
        set_cfg(0, 0, 0, 1, 1, 1, 1, 1);
        cyc(1, 1, 12'h155, 12'h2AA, 12'h3CC, "R8 per-channel frame");
        for (int i = 0; i < 40; i++)
            cyc(0, (i % 7) != 2, 12'(i * 101 + 5), 12'(i * 53 + 900), 12'(3000 - i * 37), "R8/R11 per-channel");

        // R10: no reseed, stream continues across the frame start
        set_cfg(0, 0, 0, 1, 0, 1, 0, 0);
        cyc(1, 1, 12'h0F0, 12'h0F0, 12'h0F0, "R10 continue frame");
        for (int i = 0; i < 12; i++)
            cyc(0, 1, 12'(i * 300), 12'(i * 150), 12'(i * 75), "R10 free run");
        cyc(0, 0, 12'h000, 12'h000, 12'h000, "R9 idle in dither");
        cyc(0, 1, 12'h100, 12'h200, 12'h300, "R9 resume");

        // R12: unsupported dither depth falls back to truncation
        set_cfg(1, 0, 0, 1, 2, 0, 1, 0);
        cyc(1, 1, 12'hABC, 12'hABC, 12'hABC, "R12 depth 2");
        chk(r_out == 12'hA80, "R12 truncation applies", r_out, 12'hA80);
        set_cfg(0, 0, 0, 1, 3, 0, 1, 0);
        cyc(1, 1, 12'h9E7, 12'h9E7, 12'h9E7, "R12 depth 3");
        chk(b_out == 12'h9E7, "R12 pass-through", b_out, 12'h9E7);
        // R12: active dither overrides truncation settings
        set_cfg(1, 1, 1, 1, 0, 0, 1, 0);
        cyc(1, 1, 12'h3FF, 12'h3FF, 12'h3FF, "R12 dither wins");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule